// File: doc/BRIEF.md
# Per-Source Edge/Level Interrupt Generator

This block turns a vector of status conditions into one interrupt line. Each source has its own sensitivity setting: it can react to a rising edge, a falling edge, or the condition's level, or it can be parked on a reserved code that detects nothing. The 2-bit setting for a source is split across two host-writable registers. One register supplies the high bits and the other the low bits, and bit `i` of each belongs to source `i`.

Each source latches a sticky flag when its selected event occurs. One clear strobe drops all flags together. An enable mask picks which sources may raise the interrupt. A separate 2-bit polarity setting maps the internal active state onto the pin and its output enable. The polarity setting has no link to the per-source settings.

Top module: `irq_edge_level_gen`

## Requirements
- R1: Write address 0 loads the high-bit register and address 1 loads the low-bit register. Source `i` uses the code {hi[i], lo[i]}, and a write takes effect from the next clock.
- R2: Code 00 (rising). When `cond_i[i]` is 1 and was 0 at the previous clock edge, `flag_o[i]` is 1 from the following cycle on.
- R3: Code 01 (falling). When `cond_i[i]` is 0 and was 1 at the previous clock edge, `flag_o[i]` is 1 from the following cycle on.
- R4: Code 10 (level). Each clock that samples `cond_i[i]` high sets `flag_o[i]`. An enabled level source with its condition high makes the block active in the next cycle, even if its flag was cleared.
- R5: Code 11 (reserved). The source never sets its flag and never contributes to the interrupt.
- R6: After reset, both code registers, the enable mask and the polarity are 0, all flags are 0, `irq_o` is 0, `irq_oe_o` is 1, and the previous-condition register is 0.
- R7: Write address 2 loads the enable mask. A disabled source still latches its flag but does not make the block active.
- R8: `clr_i` clears every flag at the next clock. A source whose event is detected in the same clock keeps its flag set.
- R9: Write address 3 loads the polarity from bits [1:0]. 00 gives `irq_o`=active with `irq_oe_o`=1. 01 gives `irq_o`=!active with `irq_oe_o`=1. 10 gives `irq_o`=0 with `irq_oe_o`=active. 11 gives `irq_o`=0 with `irq_oe_o`=0.
- R10: The internal active state is registered. It is 1 in the cycle after a clock at which some enabled source had its flag set or was an enabled level source with its condition high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 high code bits, 1 low code bits, 2 enable mask, 3 polarity |
| wr_data_i | input | N_SRC | Write data |
| cond_i | input | N_SRC | Condition inputs, synchronous to clk_i |
| clr_i | input | 1 | Clear all flags |
| flag_o | output | N_SRC | Latched flags |
| irq_o | output | 1 | Interrupt pin level |
| irq_oe_o | output | 1 | Interrupt pin drive enable |

## Verification
A flag clear and a new detection on the same source can land in the same clock. The detection must win, because the host has already read the old flags. The bench provokes this directly by raising a rising-edge condition in the very cycle that `clr_i` is asserted. It also lets random stimulus assert `clr_i` while conditions toggle. Every outcome is judged against a cycle model in the bench that applies set-over-clear for each source.

// File: rtl/irq_gen_pkg.sv
package irq_gen_pkg;
  typedef enum logic [1:0] {
    MODE_RISE  = 2'b00,
    MODE_FALL  = 2'b01,
    MODE_LEVEL = 2'b10,
    MODE_RSVD  = 2'b11
  } irq_mode_e;

  typedef enum logic [1:0] {
    POL_HIGH   = 2'b00,
    POL_LOW    = 2'b01,
    POL_ODRAIN = 2'b10,
    POL_RSVD   = 2'b11
  } irq_pol_e;

  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] REG_MODE_HI = 2'd0;
  localparam logic [ADDR_W-1:0] REG_MODE_LO = 2'd1;
  localparam logic [ADDR_W-1:0] REG_ENABLE  = 2'd2;
  localparam logic [ADDR_W-1:0] REG_POL     = 2'd3;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_gen_pkg::*;
#(
  parameter int unsigned N_SRC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [N_SRC-1:0]  wr_data_i,
  output logic [N_SRC-1:0]  mode_hi_o,
  output logic [N_SRC-1:0]  mode_lo_o,
  output logic [N_SRC-1:0]  enable_o,
  output irq_pol_e          pol_o
);
  logic [N_SRC-1:0] hi_q, lo_q, en_q;
  irq_pol_e         pol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      lo_q  <= '0;
      en_q  <= '0;
      pol_q <= POL_HIGH;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        REG_MODE_HI: hi_q  <= wr_data_i;
        REG_MODE_LO: lo_q  <= wr_data_i;
        REG_ENABLE:  en_q  <= wr_data_i;
        default:     pol_q <= irq_pol_e'(wr_data_i[1:0]);
      endcase
    end
  end

  assign mode_hi_o = hi_q;
  assign mode_lo_o = lo_q;
  assign enable_o  = en_q;
  assign pol_o     = pol_q;

  assert_en_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == REG_ENABLE) |=> (enable_o == $past(wr_data_i)));
endmodule

// File: rtl/irq_src_detect.sv
module irq_src_detect
  import irq_gen_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cond_i,
  input  irq_mode_e mode_i,
  input  logic      clr_i,
  output logic      flag_o,
  output logic      level_o
);
  logic cond_q, flag_q, hit;

  always_comb begin
    unique case (mode_i)
      MODE_RISE:  hit = cond_i & ~cond_q;
      MODE_FALL:  hit = ~cond_i & cond_q;
      MODE_LEVEL: hit = cond_i;
      default:    hit = 1'b0;
    endcase
  end

  // set wins over clear so an event in the clearing cycle is not lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cond_q <= cond_i;
      flag_q <= hit | (flag_q & ~clr_i);
    end
  end

  assign flag_o  = flag_q;
  assign level_o = (mode_i == MODE_LEVEL) & cond_i;

  assert_rise_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_RISE && cond_i && !cond_q) |=> flag_q);
  assert_fall_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FALL && !cond_i && cond_q) |=> flag_q);
  assert_rsvd_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_RSVD && !flag_q) |=> !flag_q);
  assert_clr_drops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && mode_i == MODE_RSVD) |=> !flag_q);
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive
  import irq_gen_pkg::*;
(
  input  irq_pol_e pol_i,
  input  logic     active_i,
  output logic     irq_o,
  output logic     irq_oe_o
);
  always_comb begin
    unique case (pol_i)
      POL_HIGH:   begin irq_o = active_i;  irq_oe_o = 1'b1;     end
      POL_LOW:    begin irq_o = ~active_i; irq_oe_o = 1'b1;     end
      POL_ODRAIN: begin irq_o = 1'b0;      irq_oe_o = active_i; end
      default:    begin irq_o = 1'b0;      irq_oe_o = 1'b0;     end
    endcase
  end

  always_comb begin
    if (pol_i == POL_ODRAIN) assert_odrain_low_R9: assert (irq_o == 1'b0);
  end
endmodule

// File: rtl/irq_edge_level_gen.sv
module irq_edge_level_gen
  import irq_gen_pkg::*;
#(
  parameter int unsigned N_SRC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [N_SRC-1:0]  wr_data_i,
  input  logic [N_SRC-1:0]  cond_i,
  input  logic              clr_i,
  output logic [N_SRC-1:0]  flag_o,
  output logic              irq_o,
  output logic              irq_oe_o
);
  logic [N_SRC-1:0] mode_hi, mode_lo, enable, flags, level;
  irq_pol_e         pol;
  logic             active_q;

  irq_cfg_regs #(.N_SRC(N_SRC)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .mode_hi_o(mode_hi), .mode_lo_o(mode_lo), .enable_o(enable), .pol_o(pol)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    irq_src_detect u_det (
      .clk_i, .rst_ni,
      .cond_i (cond_i[i]),
      .mode_i (irq_mode_e'({mode_hi[i], mode_lo[i]})),
      .clr_i,
      .flag_o (flags[i]),
      .level_o(level[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else         active_q <= |(enable & (flags | level));
  end

  irq_pin_drive u_pin (.pol_i(pol), .active_i(active_q), .irq_o, .irq_oe_o);

  assign flag_o = flags;

  assert_active_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(enable & flags)) |=> active_q);
  assert_masked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable == '0) |=> !active_q);
endmodule

// File: tb/irq_edge_level_gen_tb.sv
module irq_edge_level_gen_tb;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, clr = 0;
  logic [1:0] wr_addr = 0;
  logic [N-1:0] wr_data = 0, cond = 0, flag;
  logic irq, irq_oe;
  int checks = 0, fails = 0;

  // bench model
  logic [N-1:0] m_hi = 0, m_lo = 0, m_en = 0, m_flag = 0, m_prev = 0;
  logic [1:0] m_pol = 0;
  logic m_act = 0;

  always #2 clk = ~clk;

  irq_edge_level_gen #(.N_SRC(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cond_i(cond), .clr_i(clr),
    .flag_o(flag), .irq_o(irq), .irq_oe_o(irq_oe)
  );

  function automatic logic [1:0] exp_pin(logic [1:0] p, logic a);
    case (p)
      2'b00: return {a, 1'b1};
      2'b01: return {~a, 1'b1};
      2'b10: return {1'b0, a};
      default: return 2'b00;
    endcase
  endfunction

  task automatic check(string tag);
    logic [1:0] e = exp_pin(m_pol, m_act);
    checks++;
    if (flag !== m_flag || irq !== e[1] || irq_oe !== e[0]) begin
      fails++;
      $display("FAIL %s flag=%h/%h irq=%b/%b oe=%b/%b", tag, flag, m_flag,
               irq, e[1], irq_oe, e[0]);
    end
  endtask

  // inputs set at negedge; model advances across one posedge; compare at next negedge
  task automatic step(string tag);
    logic [N-1:0] det, lvl, nflag;
    logic nact;
    for (int i = 0; i < N; i++) begin
      logic [1:0] c = {m_hi[i], m_lo[i]};
      det[i] = (c == 2'b00) ? (cond[i] & ~m_prev[i]) :
               (c == 2'b01) ? (~cond[i] & m_prev[i]) :
               (c == 2'b10) ? cond[i] : 1'b0;
      lvl[i] = (c == 2'b10) & cond[i];
    end
    nflag = det | (m_flag & ~{N{clr}});
    nact  = |(m_en & (m_flag | lvl));
    @(posedge clk);
    m_flag = nflag; m_act = nact; m_prev = cond;
    if (wr_en) case (wr_addr)
      2'd0: m_hi = wr_data;
      2'd1: m_lo = wr_data;
      2'd2: m_en = wr_data;
      default: m_pol = wr_data[1:0];
    endcase
    @(negedge clk);
    check(tag);
  endtask

  task automatic wr(logic [1:0] a, logic [N-1:0] d, string tag);
    wr_en = 1; wr_addr = a; wr_data = d;
    step(tag);
    wr_en = 0;
  endtask

  initial begin
    #40000;
    fails++;
    $display("FAIL watchdog R10 act=timeout exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R6");
    step("R6");
    wr(2'd2, 8'hFF, "R7");
    cond[0] = 1; step("R2"); step("R2");           // rising on src0
    clr = 1; step("R8"); clr = 0; step("R8");
    wr(2'd0, 8'h02, "R1"); wr(2'd1, 8'h01, "R1"); // src0 falling, src1 level
    cond[1] = 1; step("R4"); step("R4");
    clr = 1; step("R4"); clr = 0;
    cond[1] = 0; step("R4"); step("R4");
    cond[0] = 0; step("R3"); step("R3");
    clr = 1; step("R8"); clr = 0; step("R8");
    cond[2] = 1; clr = 1; step("R8"); clr = 0; step("R8"); // set beats clear
    wr(2'd0, 8'h08, "R5"); wr(2'd1, 8'h08, "R5");          // src3 reserved
    clr = 1; step("R5"); clr = 0;
    cond[3] = 1; step("R5"); cond[3] = 0; step("R5"); step("R5");
    wr(2'd2, 8'h00, "R7");
    cond[4] = 1; step("R7"); step("R7"); step("R7");
    wr(2'd2, 8'h10, "R10"); step("R10");
    for (int p = 0; p < 4; p++) begin
      wr(2'd3, N'(p), "R9"); step("R9");
      clr = 1; step("R9"); clr = 0; step("R9"); step("R9");
      cond[4] = 0; step("R9"); cond[4] = 1; step("R9"); step("R9");
    end
    wr(2'd3, 8'h00, "R9");
    for (int k = 0; k < 400; k++) begin
      wr_en = ($urandom_range(0, 4) == 0);
      wr_addr = 2'($urandom_range(0, 3));
      wr_data = N'($urandom);
      cond = N'($urandom);
      clr = ($urandom_range(0, 6) == 0);
      step("R10");
    end
    wr_en = 0; clr = 0;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule